// File: doc/BRIEF.md
# Sixteen-Bit Multi-Mode Overflow Timer

This block is a general-purpose timer with a count register, a period register and a sixteen-bit control word. The count clock is picked from four single-cycle tick inputs. Each input is a synchronous enable in the system clock domain: one external tick, one auxiliary tick, one sub-system tick and one alternate external tick.

The selected tick passes through a divider set to 1, 2, 4 or 8, and each divided tick advances the count. There are four counting patterns: halted, up to the period value, free-running over the full range, and a triangle from zero up to the period and back down. Each time the count returns to zero, the block raises an overflow flag. When the local enable is set, the flag drives an interrupt request.

Software writes the control word, the count and the period through three write strobes that share one data bus. All three registers can be read back at any time. The control word carries a self-clearing restart bit. This bit zeroes the count, the divider phase and the triangle direction in a single write.

Top module: `ovf_timer16`

## Requirements
- R1: After a synchronous reset, the count, the period, the control readback and the interrupt output are all zero.
- R2: Control bits 9:8 pick the count tick: 00 external, 01 auxiliary, 10 sub-system, 11 alternate external. Ticks on the inputs that are not selected do not change the count.
- R3: Control bits 7:6 set the divider: 00 is /1, 01 is /2, 10 is /4, 11 is /8. The count advances once for every N selected ticks, counted from the last restart.
- R4: With control bits 5:4 at 00 (halted), the count and the divider phase hold, whatever ticks arrive.
- R5: With mode 01 (up), the count steps up on each divided tick. A tick that arrives while the count is at or above the period returns the count to 0 and sets the flag.
- R6: With mode 10 (continuous), the count wraps from 0xFFFF to 0x0000 and sets the flag on that tick.
- R7: With mode 11 (triangle), the count rises to the period value, then falls. Reaching 0 on the way down sets the flag and turns the direction back to up. With a period of 0, the count rests at 0 and the flag is not set.
- R8: Writing the control word with bit 2 set zeroes the count, the divider phase and the direction, and stores the other fields of that write. Bit 2 always reads back as 0.
- R9: Control bit 3 and bits 15:10 read back as 0, whatever is written to them.
- R10: Control bit 0 is the overflow flag. A control write loads it from the written bit 0. A hardware set in the same cycle as a software write of 0 wins, so the flag ends up 1.
- R11: The interrupt output equals the flag AND control bit 1 (local enable), in the same cycle.
- R12: A count write loads the count and takes precedence over a restart and over a tick in that cycle. A period write loads the period. Every write is visible on the readback outputs on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_tick_ext | input | 1 | External tick enable (source 00) |
| src_tick_aux | input | 1 | Auxiliary tick enable (source 01) |
| src_tick_sub | input | 1 | Sub-system tick enable (source 10) |
| src_tick_alt | input | 1 | Alternate external tick enable (source 11) |
| ctl_we | input | 1 | Write strobe for the control word |
| cnt_we | input | 1 | Write strobe for the count |
| per_we | input | 1 | Write strobe for the period |
| wr_data | input | W | Shared write data; the control word uses bits 15:0 |
| ctl_q | output | 16 | Control word readback |
| cnt_q | output | W | Count readback |
| per_q | output | W | Period readback |
| irq | output | 1 | Overflow interrupt request |

## Verification
The hardest case to reach is a flag clear that lands in the same cycle as a wrap. It needs the count at 0xFFFF, a divided tick pending and a control write, all in one cycle. The stimulus loads the count to 0xFFFF with the divider at /1, then issues a control write of flag 0 together with an active tick. The triangle turnaround and a restart issued while counting down are reached by running a small period for many cycles, then restarting part-way down. A long random phase with rare writes then mixes modes, dividers and sources while a behavioural model is compared against the outputs every cycle.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int CTL_W    = 16;
  localparam int SRC_LSB  = 8;
  localparam int DIV_LSB  = 6;
  localparam int MODE_LSB = 4;
  localparam int CLR_BIT  = 2;
  localparam int IE_BIT   = 1;
  localparam int FLG_BIT  = 0;
  localparam int SEL_W    = 2;

  typedef enum logic [1:0] {
    MODE_HALT = 2'b00,
    MODE_UP   = 2'b01,
    MODE_FREE = 2'b10,
    MODE_TRI  = 2'b11
  } tmr_mode_e;
endpackage

// File: rtl/tmr16_ctl.sv
module tmr16_ctl
  import tmr16_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  input  logic             wrap,
  output logic [SEL_W-1:0] src,
  output logic [SEL_W-1:0] div,
  output tmr_mode_e        mode,
  output logic             clr,
  output logic [CTL_W-1:0] ctl_rd,
  output logic             irq
);
  logic ie_q, flag_q, irq_q;
  logic ie_d, flag_d;

  assign clr = wr & wdata[CLR_BIT];

  always_comb begin
    ie_d   = wr ? wdata[IE_BIT] : ie_q;
    flag_d = flag_q;
    if (wr)   flag_d = wdata[FLG_BIT];
    if (wrap) flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      src    <= '0;
      div    <= '0;
      mode   <= MODE_HALT;
      ie_q   <= 1'b0;
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr) begin
        src  <= wdata[SRC_LSB +: SEL_W];
        div  <= wdata[DIV_LSB +: SEL_W];
        mode <= tmr_mode_e'(wdata[MODE_LSB +: 2]);
      end
      ie_q   <= ie_d;
      flag_q <= flag_d;
      irq_q  <= ie_d & flag_d;
    end
  end

  always_comb begin
    ctl_rd = '0;
    ctl_rd[SRC_LSB +: SEL_W]  = src;
    ctl_rd[DIV_LSB +: SEL_W]  = div;
    ctl_rd[MODE_LSB +: 2]     = mode;
    ctl_rd[IE_BIT]            = ie_q;
    ctl_rd[FLG_BIT]           = flag_q;
  end

  assign irq = irq_q;

  assert_irq_gate_R11: assert property (@(posedge clk) disable iff (rst)
    irq_q == (ie_q & flag_q));

  assert_hw_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
    wrap |=> flag_q);
endmodule

// File: rtl/tmr16_presc.sv
module tmr16_presc
  import tmr16_pkg::*;
#(
  parameter int NSRC = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic [NSRC-1:0]  ticks,
  input  logic [SEL_W-1:0] src,
  input  logic [SEL_W-1:0] div,
  output logic             ctick
);
  localparam int MAX_SH = (1 << SEL_W) - 1;
  localparam int PW     = MAX_SH + 1;

  logic [PW-1:0] phase_q;
  logic [PW-1:0] last;
  logic          sel;

  assign sel   = ticks[src];
  assign last  = PW'((1 << div) - 1);
  assign ctick = run & sel & ~clr & (phase_q >= last);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      phase_q <= '0;
    end else if (run && sel) begin
      if (phase_q >= last) phase_q <= '0;
      else                 phase_q <= phase_q + 1'b1;
    end
  end

  assert_halt_no_tick_R4: assert property (@(posedge clk) disable iff (rst)
    !run |-> !ctick);

  assert_restart_phase_R8: assert property (@(posedge clk) disable iff (rst)
    clr |=> phase_q == '0);
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
  import tmr16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_wr,
  input  logic         per_wr,
  input  logic [W-1:0] wdata,
  input  logic         clr,
  input  logic         ctick,
  input  tmr_mode_e    mode,
  output logic [W-1:0] cnt,
  output logic [W-1:0] per,
  output logic         wrap
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_d;
  logic         down_q, down_d;

  always_comb begin
    cnt_d  = cnt;
    down_d = down_q;
    wrap   = 1'b0;
    if (cnt_wr) begin
      cnt_d = wdata;
    end else if (clr) begin
      cnt_d = '0;
    end else if (ctick) begin
      unique case (mode)
        MODE_UP: begin
          if (cnt >= per) begin
            cnt_d = '0;
            wrap  = 1'b1;
          end else begin
            cnt_d = cnt + 1'b1;
          end
        end
        MODE_FREE: begin
          cnt_d = cnt + 1'b1;
          wrap  = (cnt == TOP);
        end
        MODE_TRI: begin
          if (!down_q) begin
            if (cnt >= per) begin
              if (per != '0) begin
                cnt_d  = cnt - 1'b1;
                down_d = 1'b1;
              end
            end else begin
              cnt_d = cnt + 1'b1;
            end
          end else if (cnt <= W'(1)) begin
            cnt_d  = '0;
            down_d = 1'b0;
            wrap   = 1'b1;
          end else begin
            cnt_d = cnt - 1'b1;
          end
        end
        default: ;
      endcase
    end
    if (clr) down_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      per    <= '0;
      down_q <= 1'b0;
    end else begin
      cnt    <= cnt_d;
      down_q <= down_d;
      if (per_wr) per <= wdata;
    end
  end

  assert_halt_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_HALT && !cnt_wr && !clr) |=> $stable(cnt));

  assert_up_bound_R5: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_UP && !cnt_wr && !per_wr && !clr && cnt <= per) |=> cnt <= per);

  assert_restart_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (clr && !cnt_wr) |=> (cnt == '0 && !down_q));

  assert_load_R12: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> cnt == $past(wdata));
endmodule

// File: rtl/ovf_timer16.sv
module ovf_timer16
  import tmr16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         src_tick_ext,
  input  logic         src_tick_aux,
  input  logic         src_tick_sub,
  input  logic         src_tick_alt,
  input  logic         ctl_we,
  input  logic         cnt_we,
  input  logic         per_we,
  input  logic [W-1:0] wr_data,
  output logic [15:0]  ctl_q,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] per_q,
  output logic         irq
);
  localparam int NSRC = 1 << SEL_W;

  logic [SEL_W-1:0] src, div;
  tmr_mode_e        mode;
  logic             clr, ctick, wrap;
  logic [NSRC-1:0]  ticks;
  logic [CTL_W-1:0] ctl_rd;

  assign ticks = {src_tick_alt, src_tick_sub, src_tick_aux, src_tick_ext};

  tmr16_ctl u_ctl (
    .clk(clk), .rst(rst), .wr(ctl_we), .wdata(wr_data[CTL_W-1:0]),
    .wrap(wrap), .src(src), .div(div), .mode(mode), .clr(clr),
    .ctl_rd(ctl_rd), .irq(irq)
  );

  tmr16_presc #(.NSRC(NSRC)) u_presc (
    .clk(clk), .rst(rst), .clr(clr), .run(mode != MODE_HALT),
    .ticks(ticks), .src(src), .div(div), .ctick(ctick)
  );

  tmr16_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .cnt_wr(cnt_we), .per_wr(per_we),
    .wdata(wr_data), .clr(clr), .ctick(ctick), .mode(mode),
    .cnt(cnt_q), .per(per_q), .wrap(wrap)
  );

  assign ctl_q = ctl_rd;

  assert_unused_zero_R9: assert property (@(posedge clk) disable iff (rst)
    ctl_q[15:10] == '0 && ctl_q[3] == 1'b0 && ctl_q[2] == 1'b0);
endmodule

// File: tb/test_ovf_timer16.sv
`timescale 1ns/1ps
module test_ovf_timer16;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] tk = '0;
  logic cw = 0, nw = 0, pw = 0;
  logic [15:0] wd = '0;
  logic [15:0] ctl_q, cnt_q, per_q;
  logic irq;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  logic [15:0] m_cnt, m_per;
  logic [1:0]  m_src, m_div, m_mode;
  logic        m_ie, m_flag, m_down;
  int          m_phase;

  always #2 clk = ~clk;

  ovf_timer16 i_ovf_timer16 (
    .clk(clk), .rst(rst),
    .src_tick_ext(tk[0]), .src_tick_aux(tk[1]), .src_tick_sub(tk[2]), .src_tick_alt(tk[3]),
    .ctl_we(cw), .cnt_we(nw), .per_we(pw), .wr_data(wd),
    .ctl_q(ctl_q), .cnt_q(cnt_q), .per_q(per_q), .irq(irq)
  );

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] m_ctl();
    return {6'b0, m_src, m_div, m_mode, 2'b0, m_ie, m_flag};
  endfunction

  task automatic m_reset();
    m_cnt = 0; m_per = 0; m_src = 0; m_div = 0; m_mode = 0;
    m_ie = 0; m_flag = 0; m_down = 0; m_phase = 0;
  endtask

  task automatic m_advance();
    bit restart, tick, wrapped, sel;
    int ratio;
    restart = cw && wd[2];
    sel     = tk[m_src];
    ratio   = 1 << m_div;
    tick    = 0;
    wrapped = 0;
    if (restart) m_phase = 0;
    else if (m_mode != 0 && sel) begin
      if (m_phase >= ratio - 1) begin m_phase = 0; tick = 1; end
      else m_phase++;
    end
    if (nw) m_cnt = wd;
    else if (restart) m_cnt = 0;
    else if (tick) begin
      if (m_mode == 1) begin
        if (m_cnt >= m_per) begin m_cnt = 0; wrapped = 1; end else m_cnt++;
      end else if (m_mode == 2) begin
        wrapped = (m_cnt == 16'hFFFF); m_cnt++;
      end else if (m_mode == 3) begin
        if (!m_down) begin
          if (m_cnt >= m_per) begin
            if (m_per != 0) begin m_cnt--; m_down = 1; end
          end else m_cnt++;
        end else if (m_cnt <= 1) begin
          m_cnt = 0; m_down = 0; wrapped = 1;
        end else m_cnt--;
      end
    end
    if (restart) m_down = 0;
    if (pw) m_per = wd;
    if (cw) begin
      m_src = wd[9:8]; m_div = wd[7:6]; m_mode = wd[5:4];
      m_ie = wd[1]; m_flag = wd[0];
    end
    if (wrapped) m_flag = 1;
  endtask

  // one cycle: compare current outputs, then drive inputs for the next edge
  task automatic step(input string tag, input logic [3:0] t, input logic c, input logic n,
                      input logic p, input logic [15:0] d);
    @(negedge clk);
    chk(tag, "count", cnt_q, m_cnt);
    chk("R12", "period", per_q, m_per);
    chk("R9", "control", ctl_q, m_ctl());
    chk("R11", "irq", {15'b0, irq}, {15'b0, m_flag & m_ie});
    tk = t; cw = c; nw = n; pw = p; wd = d;
    m_advance();
  endtask

  task automatic idle(input string tag, input int cycles, input logic [3:0] t);
    for (int i = 0; i < cycles; i++) step(tag, t, 0, 0, 0, 16'h0);
  endtask

  function automatic logic [15:0] cword(input int s, input int dv, input int md, input bit c, input bit ie, input bit f);
    return 16'((s << 8) | (dv << 6) | (md << 4) | (int'(c) << 2) | (int'(ie) << 1) | int'(f));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state
    chk("R1", "count", cnt_q, 16'h0);
    chk("R1", "control", ctl_q, 16'h0);
    chk("R1", "period", per_q, 16'h0);
    chk("R1", "irq", {15'b0, irq}, 16'h0);

    // R5: up mode, period 5, sub-system source /1, enable on
    step("R12", 4'b0000, 0, 0, 1, 16'd5);
    step("R5", 4'b0100, 1, 0, 0, cword(2, 0, 1, 0, 1, 0));
    idle("R5", 20, 4'b0100);
    chk("R5", "flag", {15'b0, ctl_q[0]}, 16'h1);
    chk("R11", "irq raised", {15'b0, irq}, 16'h1);

    // R2: alternate source selected, other inputs busy
    step("R2", 4'b0000, 1, 0, 0, cword(3, 0, 1, 1, 0, 0));
    idle("R2", 10, 4'b0111);
    chk("R2", "held count", cnt_q, 16'h0);
    idle("R2", 3, 4'b1000);

    // R4: halted mode ignores ticks
    step("R4", 4'b0000, 1, 0, 0, cword(0, 0, 0, 0, 0, 0));
    step("R12", 4'b0000, 0, 1, 0, 16'h1234);
    idle("R4", 12, 4'b1111);
    chk("R4", "halted count", cnt_q, 16'h1234);

    // R6: continuous wrap, auxiliary /2 with irregular ticks
    step("R12", 4'b0000, 0, 1, 0, 16'hFFF0);
    step("R6", 4'b0000, 1, 0, 0, cword(1, 1, 2, 0, 1, 0));
    for (int i = 0; i < 60; i++) step("R6", {2'b0, 1'($urandom_range(0, 1)), 1'b0}, 0, 0, 0, 16'h0);

    // R10: software clear coincides with a wrap; hardware wins
    step("R10", 4'b0000, 1, 0, 0, cword(1, 0, 2, 1, 1, 0));
    step("R12", 4'b0000, 0, 1, 0, 16'hFFFF);
    step("R10", 4'b0010, 1, 0, 0, cword(1, 0, 2, 0, 1, 0));
    step("R10", 4'b0000, 0, 0, 0, 16'h0);
    chk("R10", "flag after race", {15'b0, ctl_q[0]}, 16'h1);
    step("R10", 4'b0000, 1, 0, 0, cword(1, 0, 2, 0, 1, 0));
    step("R10", 4'b0000, 0, 0, 0, 16'h0);
    chk("R10", "flag cleared", {15'b0, ctl_q[0]}, 16'h0);

    // R7: triangle, period 3, external /4
    step("R12", 4'b0000, 0, 0, 1, 16'd3);
    step("R7", 4'b0000, 1, 0, 0, cword(0, 2, 3, 1, 0, 0));
    idle("R7", 70, 4'b0001);
    // R8: restart while counting down
    idle("R7", 5, 4'b0001);
    step("R8", 4'b0001, 1, 0, 0, cword(0, 0, 3, 1, 0, 0));
    step("R8", 4'b0001, 0, 0, 0, 16'h0);
    chk("R8", "count after restart", cnt_q, 16'h0);
    idle("R8", 12, 4'b0001);
    // R7: period 0 rests at zero
    step("R12", 4'b0000, 0, 0, 1, 16'd0);
    step("R7", 4'b0000, 1, 0, 0, cword(0, 0, 3, 1, 0, 0));
    idle("R7", 6, 4'b0001);
    chk("R7", "zero period rest", cnt_q, 16'h0);

    // R3: divide by 8 with random ticks
    step("R3", 4'b0000, 1, 0, 0, cword(2, 3, 2, 1, 0, 0));
    for (int i = 0; i < 80; i++) step("R3", {1'b0, 1'($urandom_range(0, 1)), 2'b0}, 0, 0, 0, 16'h0);
    step("R3", 4'b0000, 1, 0, 0, cword(2, 1, 2, 1, 0, 0));
    idle("R3", 9, 4'b0100);

    // R9: all-ones control write
    step("R9", 4'b0000, 1, 0, 0, 16'hFFFF);
    step("R9", 4'b0000, 0, 0, 0, 16'h0);
    chk("R9", "readback", ctl_q, 16'h03F3);
    chk("R8", "restart bit reads 0", {15'b0, ctl_q[2]}, 16'h0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] d;
      int r;
      r = $urandom_range(0, 31);
      d = 16'($urandom);
      if (r == 3) d = 16'($urandom_range(0, 9));
      step("R12", 4'($urandom), r == 0, r == 1 || r == 3, r == 2 || r == 4, d);
    end
    step("R12", 4'b0000, 0, 0, 0, 16'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule